// File: doc/BRIEF.md
# Multiprocessor UART Receiver with Masked Address Filter

This block receives asynchronous serial frames made of a start bit, eight data bits sent least significant bit first, a ninth bit, and a stop bit. The line is sampled against an oversampling tick that runs at sixteen times the bit rate. Each bit is decided near its centre by a two-out-of-three vote. A received frame is presented as a byte plus its ninth bit and is announced by a sticky done flag. A stop bit that reads low raises a sticky framing-error flag.

When the multiprocessor mode is enabled, a frame whose ninth bit is 1 is an address frame. It is compared with a node address, and a mask picks which bits take part in the comparison. A matching address frame is delivered and opens the node for the data frames that follow, which have ninth bit 0. A non-matching address frame is discarded without raising any flag and closes the node, so later data frames are discarded too. A broadcast pattern, made from the node address and the mask, is always accepted. Both flags are cleared only through dedicated clear inputs, which software drives.

Top module: `uart_addr_rx`

## Requirements
- R1: After a frame with a high stop bit that is accepted, `rx_byte` holds the eight data bits (the first data bit received is bit 0), `rx_bit9` holds the ninth bit, and `rx_done` is set near the middle of the stop bit. After reset `rx_done`, `frame_err` and `rx_byte` are 0.
- R2: Each bit is decided by a majority of three line samples taken at oversampling ticks 7, 8 and 9 of the bit. A low pulse on the idle line that is shorter than half a bit yields no frame, and a frame sent after it is received correctly.
- R3: When the stop bit is decided low, `frame_err` is set. The frame is not delivered: `rx_done`, `rx_byte` and `rx_bit9` keep their values.
- R4: `frame_err` stays set until `ferr_clr` is pulsed. Later good frames do not clear it.
- R5: `rx_done` stays set until `done_clr` is pulsed. Receiving a frame is the only thing that sets it.
- R6: With `mp_en` = 1, an address frame (ninth bit 1) matches when each data bit whose `addr_mask` bit is 1 equals the same bit of `node_addr`. A matching address frame is delivered.
- R7: With `mp_en` = 1, an address frame that neither matches nor is a broadcast is not delivered and closes the node. Data frames (ninth bit 0) that arrive while the node is closed are not delivered, and `rx_byte` is unchanged.
- R8: With `mp_en` = 1, an address frame is a broadcast when every bit that is 1 in `node_addr | addr_mask` is also 1 in the data. A broadcast is delivered and opens the node.
- R9: With `mp_en` = 1, data frames that follow a matching or broadcast address frame are delivered.
- R10: With `mp_en` = 0, every frame with a high stop bit is delivered, whatever its ninth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| os_tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| mp_en | input | 1 | Multiprocessor address filtering enable |
| node_addr | input | 8 | Given node address |
| addr_mask | input | 8 | Address mask; a 1 makes the bit significant |
| done_clr | input | 1 | Clears `rx_done` |
| ferr_clr | input | 1 | Clears `frame_err` |
| rx_byte | output | 8 | Last delivered data byte |
| rx_bit9 | output | 1 | Ninth bit of the last delivered frame |
| rx_done | output | 1 | Sticky frame-delivered flag |
| frame_err | output | 1 | Sticky missing-stop-bit flag |

## Verification
The bench sends a short low glitch on the idle line. A receiver that does not check the start bit at its centre would take the glitch for a start and then read the next real frame out of step. It also sends a frame with a low stop bit. A receiver that delivers such a frame, or that clears the error flag on the next good frame, changes `rx_byte` or loses `frame_err`. In multiprocessor mode it uses masks with don't-care bits in the middle of the byte and one address that differs only in a significant bit. A filter that compares all bits, or one that ignores the mask, would accept or reject the wrong frames. Data frames are sent after a rejected address and after a broadcast, which shows whether the node opens and closes on the right frames.

// File: rtl/uarx_pkg.sv
package uarx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/uarx_sampler.sv
// Holds two mid-bit samples and votes with the third, live one.
module uarx_sampler #(
    parameter int OSR = 16,
    parameter int CW  = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    input  logic          line,
    output logic          vote_en,
    output logic          vote
);
    localparam int MID = OSR / 2;

    logic [1:0] smp_d, smp_q;

    always_comb begin
        smp_d = smp_q;
        if (tick && cnt == CW'(MID - 1)) smp_d[0] = line;
        if (tick && cnt == CW'(MID))     smp_d[1] = line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= 2'b11;
        else        smp_q <= smp_d;
    end

    assign vote_en = tick && (cnt == CW'(MID + 1));
    assign vote    = (smp_q[0] & smp_q[1]) | (smp_q[0] & line) | (smp_q[1] & line);
endmodule

// File: rtl/uarx_addr_match.sv
// Masked address compare plus broadcast detection.
module uarx_addr_match #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] frame_dat,
    input  logic [DW-1:0] node_addr,
    input  logic [DW-1:0] addr_mask,
    output logic          hit
);
    logic [DW-1:0] bcast;
    logic          own_hit, bc_hit;

    always_comb begin
        bcast   = node_addr | addr_mask;
        own_hit = ((frame_dat ^ node_addr) & addr_mask) == '0;
        bc_hit  = (frame_dat & bcast) == bcast;
        hit     = own_hit | bc_hit;
    end
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
    import uarx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd,
    input  logic          os_tick,
    input  logic          mp_en,
    input  logic [DW-1:0] node_addr,
    input  logic [DW-1:0] addr_mask,
    input  logic          done_clr,
    input  logic          ferr_clr,
    output logic [DW-1:0] rx_byte,
    output logic          rx_bit9,
    output logic          rx_done,
    output logic          frame_err
);
    localparam int FW = DW + 1;
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(FW);

    typedef struct packed {
        logic [1:0]    sync;
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bidx;
        logic [FW-1:0] sh;
        logic [DW-1:0] dat;
        logic          b9;
        logic          done;
        logic          ferr;
        logic          armed;
    } rx_regs_t;

    rx_regs_t r_d, r_q;
    logic     line, vote_en, vote, addr_hit, last_tick;

    assign line = r_q.sync[1];

    uarx_sampler #(.OSR(OSR), .CW(CW)) u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .cnt     (r_q.cnt),
        .line    (line),
        .vote_en (vote_en),
        .vote    (vote)
    );

    uarx_addr_match #(.DW(DW)) u_match (
        .frame_dat (r_q.sh[DW-1:0]),
        .node_addr (node_addr),
        .addr_mask (addr_mask),
        .hit       (addr_hit)
    );

    assign last_tick = os_tick && (r_q.cnt == CW'(OSR - 1));

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[0], rxd};
        if (done_clr) r_d.done = 1'b0;
        if (ferr_clr) r_d.ferr = 1'b0;

        if (r_q.st != RX_IDLE && os_tick) begin
            r_d.cnt = last_tick ? '0 : r_q.cnt + CW'(1);
        end

        unique case (r_q.st)
            RX_IDLE: begin
                if (os_tick && !line) begin
                    r_d.st  = RX_START;
                    r_d.cnt = CW'(1);
                end
            end
            RX_START: begin
                if (vote_en && vote) begin
                    r_d.st  = RX_IDLE;
                    r_d.cnt = '0;
                end else if (last_tick) begin
                    r_d.st   = RX_DATA;
                    r_d.bidx = '0;
                end
            end
            RX_DATA: begin
                if (vote_en) r_d.sh = {vote, r_q.sh[FW-1:1]};
                if (last_tick) begin
                    if (r_q.bidx == BW'(FW - 1)) r_d.st = RX_STOP;
                    else                         r_d.bidx = r_q.bidx + BW'(1);
                end
            end
            RX_STOP: begin
                if (vote_en) begin
                    r_d.st  = RX_IDLE;
                    r_d.cnt = '0;
                    if (!vote) begin
                        r_d.ferr = 1'b1;
                    end else if (!mp_en ||
                                 (r_q.sh[FW-1] && addr_hit) ||
                                 (!r_q.sh[FW-1] && r_q.armed)) begin
                        r_d.dat  = r_q.sh[DW-1:0];
                        r_d.b9   = r_q.sh[FW-1];
                        r_d.done = 1'b1;
                    end
                    if (vote && mp_en && r_q.sh[FW-1]) r_d.armed = addr_hit;
                end
            end
            default: r_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.sync <= 2'b11;
            r_q.st   <= RX_IDLE;
            r_q.sh   <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_byte   = r_q.dat;
    assign rx_bit9   = r_q.b9;
    assign rx_done   = r_q.done;
    assign frame_err = r_q.ferr;
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done_clr,
    input logic          ferr_clr,
    input logic [DW-1:0] rx_byte,
    input logic          rx_done,
    input logic          frame_err
);
    // R4
    ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_err) |-> $past(ferr_clr));

    // R5
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_done) |-> $past(done_clr));

    // R1
    byte_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> rx_done);

    // R3
    bad_stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> $stable(rx_byte));
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_clr  (done_clr),
    .ferr_clr  (ferr_clr),
    .rx_byte   (rx_byte),
    .rx_done   (rx_done),
    .frame_err (frame_err)
);

// File: tb/tb_uart_addr_rx.sv
`timescale 1ns/1ps
module tb_uart_addr_rx;
    localparam int BIT_CLKS = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       os_tick = 1'b0;
    logic       mp_en = 1'b0;
    logic [7:0] node_addr = 8'h00;
    logic [7:0] addr_mask = 8'h00;
    logic       done_clr = 1'b0;
    logic       ferr_clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_bit9, rx_done, frame_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    uart_addr_rx dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick), .mp_en(mp_en),
        .node_addr(node_addr), .addr_mask(addr_mask), .done_clr(done_clr),
        .ferr_clr(ferr_clr), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
        .rx_done(rx_done), .frame_err(frame_err)
    );

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input logic b9, input logic stop_ok);
        logic [10:0] f;
        f = {stop_ok, b9, b, 1'b0};
        for (int i = 0; i < 11; i++) begin
            rxd = f[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic pulse_done_clr();
        done_clr = 1'b1; @(negedge clk); done_clr = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_ferr_clr();
        ferr_clr = 1'b1; @(negedge clk); ferr_clr = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 reset done", {8'h0, rx_done}, 9'h0);
        check("R1 reset ferr", {8'h0, frame_err}, 9'h0);
        check("R1 reset byte", {1'b0, rx_byte}, 9'h0);
    endtask

    task automatic t_plain();
        mp_en = 1'b0;
        send_frame(8'hA5, 1'b1, 1'b1);
        check("R1 done", {8'h0, rx_done}, 9'h1);
        check("R1 byte+bit9", {rx_bit9, rx_byte}, {1'b1, 8'hA5});
        repeat (300) @(negedge clk);
        check("R5 done held", {8'h0, rx_done}, 9'h1);
        pulse_done_clr();
        check("R5 done cleared", {8'h0, rx_done}, 9'h0);
        send_frame(8'h3C, 1'b0, 1'b1);
        check("R10 mp off ninth 0", {rx_bit9, rx_byte}, {1'b0, 8'h3C});
        check("R10 done", {8'h0, rx_done}, 9'h1);
        pulse_done_clr();
    endtask

    task automatic t_glitch();
        rxd = 1'b0; repeat (20) @(negedge clk); rxd = 1'b1;
        repeat (300) @(negedge clk);
        check("R2 glitch no frame", {8'h0, rx_done}, 9'h0);
        send_frame(8'h5A, 1'b1, 1'b1);
        check("R2 frame after glitch", {rx_bit9, rx_byte}, {1'b1, 8'h5A});
        pulse_done_clr();
    endtask

    task automatic t_ferr();
        send_frame(8'h77, 1'b0, 1'b0);
        repeat (100) @(negedge clk);
        check("R3 ferr set", {8'h0, frame_err}, 9'h1);
        check("R3 not delivered", {8'h0, rx_done}, 9'h0);
        check("R3 byte kept", {rx_bit9, rx_byte}, {1'b1, 8'h5A});
        send_frame(8'h11, 1'b1, 1'b1);
        check("R4 good frame in", {1'b0, rx_byte}, 9'h11);
        check("R4 ferr still set", {8'h0, frame_err}, 9'h1);
        pulse_ferr_clr();
        check("R4 ferr cleared", {8'h0, frame_err}, 9'h0);
        pulse_done_clr();
    endtask

    task automatic t_match();
        mp_en = 1'b1; node_addr = 8'hC0; addr_mask = 8'hF9;
        send_frame(8'hC6, 1'b1, 1'b1);
        check("R6 masked match done", {8'h0, rx_done}, 9'h1);
        check("R6 addr byte", {rx_bit9, rx_byte}, {1'b1, 8'hC6});
        pulse_done_clr();
        send_frame(8'h33, 1'b0, 1'b1);
        check("R9 data after match", {rx_bit9, rx_byte}, {1'b0, 8'h33});
        check("R9 done", {8'h0, rx_done}, 9'h1);
        pulse_done_clr();
        send_frame(8'hC1, 1'b1, 1'b1);
        check("R7 mismatch dropped", {8'h0, rx_done}, 9'h0);
        send_frame(8'h44, 1'b0, 1'b1);
        check("R7 data while closed", {8'h0, rx_done}, 9'h0);
        check("R7 byte kept", {1'b0, rx_byte}, 9'h33);
    endtask

    task automatic t_bcast();
        node_addr = 8'hE0; addr_mask = 8'hFC;
        send_frame(8'hE3, 1'b1, 1'b1);
        check("R6 match dont-care low", {rx_bit9, rx_byte}, {1'b1, 8'hE3});
        pulse_done_clr();
        send_frame(8'hE4, 1'b1, 1'b1);
        check("R7 significant bit differs", {8'h0, rx_done}, 9'h0);
        send_frame(8'hFC, 1'b1, 1'b1);
        check("R8 broadcast done", {8'h0, rx_done}, 9'h1);
        check("R8 broadcast byte", {1'b0, rx_byte}, 9'hFC);
        pulse_done_clr();
        send_frame(8'h99, 1'b0, 1'b1);
        check("R9 data after broadcast", {rx_bit9, rx_byte}, {1'b0, 8'h99});
        pulse_done_clr();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        t_plain();
        t_glitch();
        t_ferr();
        t_match();
        t_bcast();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule